// File: doc/BRIEF.md
# Stepped Soft-Start Reference Sequencer

This block generates the digital reference code for a power-factor controller's voltage loop during start-up. Once the supply is good and input voltage is present, the code climbs from a low start value to the regulation value (the code standing for 2.5 V) in equal stairs. Each stair lasts a fixed number of slow timebase ticks, so the whole climb takes about 5 ms. While the code is climbing, `ss_active` tells the loop that the internal proportional start-up controller is in charge. After the final code is reached, a transition timer runs (about 30 ms by default). When it expires, `handover` rises and control passes to the external compensator.

Losing the supply good signal (undervoltage lockout) returns everything to the initial state. Losing input voltage does the same, and the sequencer then waits until input voltage returns before it climbs again. The FSM has five states. SS_OFF is the supply-not-good state. SS_HOLD_VIN means the supply is good but input is absent. SS_CLIMB is the staircase. SS_SETTLE means the final code is held while the transition timer runs. SS_HANDED means the handover is done.

The transitions are these:
- Any state goes to SS_OFF when supply_ok is low.
- With supply_ok high, any state goes to SS_HOLD_VIN when vin_present is low.
- SS_OFF goes to SS_CLIMB when both inputs are high.
- SS_HOLD_VIN goes to SS_CLIMB when vin_present is high.
- SS_CLIMB goes to SS_SETTLE on the tick that completes the last stair.
- SS_SETTLE goes to SS_HANDED on the tick that completes the transition timer.

Top module: `softstart_ref_seq`

## Requirements
- R1: While rst_n is low, ref_code equals START_CODE and ss_active and handover are 0.
- R2: When supply_ok and vin_present are both high at a clock edge in SS_OFF or SS_HOLD_VIN, the next cycle shows ss_active = 1 with ref_code = START_CODE.
- R3: While climbing, after n counted ticks (a tick counts when tick is high at a rising clock edge), ref_code equals START_CODE + floor(n / TICKS_PER_STEP) * floor((FINAL_CODE - START_CODE) / NUM_STEPS). The code never decreases.
- R4: After NUM_STEPS * TICKS_PER_STEP counted ticks, ref_code equals FINAL_CODE exactly, even when the step size does not divide the span. ref_code never exceeds FINAL_CODE.
- R5: ss_active is 1 exactly while climbing. It falls in the same cycle that ref_code becomes FINAL_CODE.
- R6: handover rises after HANDOVER_TICKS further counted ticks at FINAL_CODE. It stays 1 while supply_ok and vin_present stay high.
- R7: With supply_ok high, vin_present low at an edge zeroes the stair and transition counters at that edge. The next cycle shows ref_code = START_CODE, ss_active = 0 and handover = 0, and the climb restarts from the first stair only after vin_present returns.
- R8: supply_ok low at an edge returns the sequencer to SS_OFF from any state. The next cycle shows ref_code = START_CODE and both flags low.
- R9: Ticks in SS_OFF and SS_HOLD_VIN have no effect. The following climb starts from zero counted ticks.
- R10: ss_active and handover are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one clock wide per tick |
| supply_ok | input | 1 | Supply above the lockout threshold |
| vin_present | input | 1 | Input voltage detected |
| ref_code | output | CODE_W | Reference code for the voltage loop |
| ss_active | output | 1 | Internal start-up controller in charge (climbing) |
| handover | output | 1 | External compensator in charge |

## Verification
The bench sweeps the point at which input voltage or supply is removed across every cycle of the climb and the settle window. A design that cleared its counters one cycle late, or resumed mid-staircase after vin_present returned, would show a stair above START_CODE on restart. Sparse tick patterns expose a design that counts clocks instead of ticks, or that lets ticks in the waiting states pre-load the staircase. The small configuration uses a span that the step count does not divide. A design that computed the last stair by multiplication alone would stop short of FINAL_CODE, and one that added a step too many would overshoot it. The exact tick on which handover rises is checked, which catches off-by-one errors in the transition timer.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        SS_OFF      = 3'd0,  // supply not good
        SS_HOLD_VIN = 3'd1,  // supply good, input voltage absent
        SS_CLIMB    = 3'd2,  // staircase in progress
        SS_SETTLE   = 3'd3,  // final code held, transition timer running
        SS_HANDED   = 3'd4   // external compensator in charge
    } ss_state_t;

endpackage

// File: rtl/ss_tick_timer.sv
module ss_tick_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic done
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(LIMIT - 1));
    assign done = en && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    // R3: the dwell count stays within its window
    a_r3_timer_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < LIMIT);

    // R7: a clear empties the timer at the very next edge
    a_r7_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

endmodule

// File: rtl/ss_step_counter.sv
module ss_step_counter #(
    parameter int NUM_STEPS = 4,
    parameter int SW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [SW-1:0] step,
    output logic          at_top
);
    assign at_top = (step == SW'(NUM_STEPS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step <= '0;
        end else if (clear) begin
            step <= '0;
        end else if (advance && !at_top) begin
            step <= step + 1'b1;
        end
    end

    // R4: the stair index never runs past the top stair
    a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(step) <= NUM_STEPS);

    // R7: a clear returns the stair index to zero
    a_r7_step_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (step == '0));

endmodule

// File: rtl/ss_stair_map.sv
module ss_stair_map #(
    parameter int CODE_W     = 8,
    parameter int START_CODE = 10,
    parameter int FINAL_CODE = 200,
    parameter int NUM_STEPS  = 4,
    parameter int SW         = 3
) (
    input  logic [SW-1:0]     step,
    output logic [CODE_W-1:0] code
);
    localparam int STEP_SZ = (FINAL_CODE - START_CODE) / NUM_STEPS;

    // The top stair is pinned to the exact target, whatever the rounding.
    always_comb begin
        if (int'(step) >= NUM_STEPS) begin
            code = CODE_W'(FINAL_CODE);
        end else begin
            code = CODE_W'(START_CODE + STEP_SZ * int'(step));
        end
    end

endmodule

// File: rtl/softstart_ref_seq.sv
module softstart_ref_seq
    import softstart_pkg::*;
#(
    parameter int CODE_W         = 10,
    parameter int START_CODE     = 64,
    parameter int FINAL_CODE     = 640,
    parameter int NUM_STEPS      = 16,
    parameter int TICKS_PER_STEP = 312,
    parameter int HANDOVER_TICKS = 30000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              supply_ok,
    input  logic              vin_present,
    output logic [CODE_W-1:0] ref_code,
    output logic              ss_active,
    output logic              handover
);
    localparam int SW = $clog2(NUM_STEPS + 1);

    ss_state_t     state, state_nx;
    logic          abort;
    logic          dwell_done, settle_done, climb_done;
    logic [SW-1:0] step;
    logic          step_top;

    assign abort = !supply_ok || !vin_present;

    // Per-stair dwell timer
    ss_tick_timer #(.LIMIT(TICKS_PER_STEP)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (abort),
        .en    (tick && (state == SS_CLIMB)),
        .done  (dwell_done)
    );

    // Stair index
    ss_step_counter #(.NUM_STEPS(NUM_STEPS), .SW(SW)) u_steps (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (abort),
        .advance (dwell_done),
        .step    (step),
        .at_top  (step_top)
    );

    // Transition timer before the compensator takes over
    ss_tick_timer #(.LIMIT(HANDOVER_TICKS)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (abort),
        .en    (tick && (state == SS_SETTLE)),
        .done  (settle_done)
    );

    ss_stair_map #(
        .CODE_W     (CODE_W),
        .START_CODE (START_CODE),
        .FINAL_CODE (FINAL_CODE),
        .NUM_STEPS  (NUM_STEPS),
        .SW         (SW)
    ) u_map (
        .step (step),
        .code (ref_code)
    );

    assign climb_done = dwell_done && (step == SW'(NUM_STEPS - 1));

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!supply_ok) begin
            state_nx = SS_OFF;
        end else if (!vin_present) begin
            state_nx = SS_HOLD_VIN;
        end else begin
            unique case (state)
                SS_OFF:      state_nx = SS_CLIMB;
                SS_HOLD_VIN: state_nx = SS_CLIMB;
                SS_CLIMB:    if (climb_done)  state_nx = SS_SETTLE;
                SS_SETTLE:   if (settle_done) state_nx = SS_HANDED;
                SS_HANDED:   state_nx = SS_HANDED;
                default:     state_nx = SS_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SS_OFF;
        else        state <= state_nx;
    end

    // Flag outputs
    always_comb begin
        ss_active = 1'b0;
        handover  = 1'b0;
        unique case (state)
            SS_CLIMB:  ss_active = 1'b1;
            SS_HANDED: handover  = 1'b1;
            default: ;
        endcase
    end

    // R8: losing the supply always lands in SS_OFF
    a_r8_uvlo_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state == SS_OFF));

    // R7: input loss lands in SS_HOLD_VIN at the starting code
    a_r7_vin_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !vin_present) |=>
            (state == SS_HOLD_VIN && ref_code == CODE_W'(START_CODE)));

    // R10: the two flags are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ss_active && handover));

    // R4: no overshoot
    a_r4_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ref_code) <= FINAL_CODE);

    // R3: the staircase only climbs
    a_r3_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_CLIMB && supply_ok && vin_present) |=>
            (ref_code >= $past(ref_code)));

    // R5: leaving the climb means the target has been reached
    a_r5_climb_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_CLIMB && supply_ok && vin_present && climb_done) |=>
            (!ss_active && ref_code == CODE_W'(FINAL_CODE)));

    // R6: handover is held while supply and input remain
    a_r6_handover_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (handover && supply_ok && vin_present) |=> handover);

endmodule

// File: tb/softstart_ref_seq_bench.sv
module softstart_ref_seq_bench;
    localparam int CW    = 8;
    localparam int START = 10;
    localparam int FINAL = 200;
    localparam int NST   = 4;
    localparam int TPS   = 3;
    localparam int HOLD  = 5;
    localparam int STEP  = (FINAL - START) / NST;  // 47, span not divisible

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          supply_ok = 1'b0;
    logic          vin_present = 1'b0;
    logic [CW-1:0] ref_code;
    logic          ss_active, handover;

    int n_tests = 0;
    int n_fail  = 0;
    // model: 0 off, 1 wait vin, 2 climb, 3 settle, 4 handed
    int m_st = 0, m_rt = 0, m_ht = 0;

    always #2 clk = ~clk;

    softstart_ref_seq #(
        .CODE_W(CW), .START_CODE(START), .FINAL_CODE(FINAL),
        .NUM_STEPS(NST), .TICKS_PER_STEP(TPS), .HANDOVER_TICKS(HOLD)
    ) u_softstart_ref_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .vin_present(vin_present), .ref_code(ref_code),
        .ss_active(ss_active), .handover(handover)
    );

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_ref();
        if (m_st == 2) return START + (m_rt / TPS) * STEP;
        if (m_st >= 3) return FINAL;
        return START;
    endfunction

    // One clock with the given inputs, model update, then compare outputs.
    task automatic cyc(bit s, bit v, bit t);
        string tg;
        @(negedge clk);
        supply_ok = s; vin_present = v; tick = t;
        @(posedge clk);
        if (!rst_n) begin
            m_st = 0; m_rt = 0; m_ht = 0;
        end else if (!s) begin
            m_st = 0; m_rt = 0; m_ht = 0;
        end else if (!v) begin
            m_st = 1; m_rt = 0; m_ht = 0;
        end else begin
            case (m_st)
                0, 1: begin m_st = 2; m_rt = 0; end
                2: begin
                    if (t) m_rt++;
                    if (m_rt == NST * TPS) begin m_st = 3; m_ht = 0; end
                end
                3: begin
                    if (t) m_ht++;
                    if (m_ht == HOLD) m_st = 4;
                end
                default: ;
            endcase
        end
        #1;
        case (m_st)
            0: tg = t ? "R9" : "R8";
            1: tg = t ? "R9" : "R7";
            2: tg = (m_rt == 0) ? "R2" : "R3";
            3: tg = "R4";
            default: tg = "R6";
        endcase
        if (!rst_n) tg = "R1";
        check(tg, int'(ref_code), exp_ref());
        check((m_st == 2 || m_st == 3) ? "R5" : tg, int'(ss_active), (m_st == 2) ? 1 : 0);
        check((m_st >= 3) ? "R6" : tg, int'(handover), (m_st == 4) ? 1 : 0);
        check("R10", int'(ss_active && handover), 0);
        check("R4", int'(int'(ref_code) <= FINAL), 1);
    endtask

    // Climb with a tick pattern: a tick every 'per' clocks, for 'n' clocks.
    task automatic run(int n, int per);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, (i % per) == per - 1);
    endtask

    initial begin
        // R1: reset state with everything asserted
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        // R8 / R9: supply off, ticks running
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1);
        // R7 / R9: waiting for input voltage with ticks
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b1);
        // R2..R6: full climb and handover, tick every clock
        run(NST * TPS + HOLD + 6, 1);
        // R7: input loss after handover, then restart with sparse ticks
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        run(3 * (NST * TPS + HOLD) + 8, 3);
        // R8: supply loss after handover
        cyc(1'b0, 1'b1, 1'b1);
        // Sweep input-loss point across climb and settle (R7)
        for (int d = 0; d < NST * TPS + HOLD + 3; d++) begin
            cyc(1'b1, 1'b0, 1'b1);
            run(d, 1);
            cyc(1'b1, 1'b0, 1'b1);
            cyc(1'b1, 1'b0, 1'b0);
            run(NST * TPS + 2, 1);   // restart from the first stair
        end
        // Sweep supply-loss point with ticks every other clock (R8)
        for (int d = 0; d < 2 * (NST * TPS + HOLD) + 3; d++) begin
            cyc(1'b0, 1'b0, 1'b0);
            run(d, 2);
            cyc(1'b0, 1'b1, 1'b1);
            run(4, 2);
        end
        // Irregular tick pattern through handover (R3, R6)
        cyc(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 80; i++) cyc(1'b1, 1'b1, ((i * 7) % 5) < 2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule